// File: doc/BRIEF.md
# Outstanding Memory Request Admission Table

This block sits between a processor's load/store path and the first-level cache request queue. Each incoming memory request is sorted into a primary kind from a handful of flags: linked-load/conditional-store, locked read-modify-write, flush, write, instruction fetch and store-check. The kind decides which of two small associative tables, one for reads and one for writes, will hold the request, keyed by its 64-byte line address. The block then answers with one of three verdicts: issued, aliased (retry later) or full. An issued request is forwarded with a queue-side type and the hit latency that applies to it.

Completions arrive separately for the read table and for the write table, each carrying a line address. A completion frees the entry that matches. Completing a locked read-modify-write read fences its line until the matching locked write completes. Four event counters record which kind of collision caused each aliasing rejection.

Top module: `mreq_admit`

## Requirements
- R1: When the entries held in both tables together number MAX_OUT or more, a request gets verdict full (code 2). This test comes before every other test, so it applies even when the line would alias, and no event counter moves.
- R2: Loads and instruction fetches are read-class and go to the read table. Every other kind is write-class and goes to the write table. The flags are decoded in this priority: link/conditional (req_llsc), then locked (req_locked), then flush, then write, then fetch, then store-check, then plain load.
- R3: A write-class request whose line is held in the read table is aliased (code 1) and bumps evt_st_ld. Otherwise, if the write table holds the line, it is aliased and bumps evt_st_st.
- R4: A read-class request whose line is held in the write table is aliased and bumps evt_ld_st. Otherwise, if the read table holds the line, it is aliased and bumps evt_ld_ld.
- R5: A request that passes R1, R3, R4 and R6 but finds no free entry in its own table gets verdict full.
- R6: Completing a locked read-modify-write read fences its line. While the fence stands, every request to that line except a locked write is aliased and no event counter moves. Completing the locked write on that line lifts the fence.
- R7: issue_type codes are 0 load, 1 fetch, 2 store, 3 atomic and 4 flush. Link/conditional requests are issued as 3. Locked reads and writes are issued as 2. A store-check read is issued as 2. Each other kind keeps its own code.
- R8: issue_lat is ICACHE_LAT for fetches and DCACHE_LAT for every other issued request.
- R9: A completion frees the entry whose line matches. A completion that matches no entry sets the sticky done_err and leaves both tables unchanged.
- R10: rsp_valid, rsp_status, issue_valid, issue_addr, issue_type and issue_lat appear one cycle after the request. issue_valid is high only when the verdict is issued (code 0). Reset empties both tables, clears the fence, the counters and done_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | Request writes memory |
| req_llsc | input | 1 | Linked load or conditional store |
| req_locked | input | 1 | Locked read-modify-write half |
| req_fetch | input | 1 | Instruction fetch |
| req_flush | input | 1 | Line flush |
| req_stchk | input | 1 | Read that intends a later store |
| rsp_valid | output | 1 | Verdict valid |
| rsp_status | output | 2 | 0 issued, 1 aliased, 2 full |
| issue_valid | output | 1 | Request forwarded to the cache queue |
| issue_addr | output | ADDR_W | Forwarded byte address |
| issue_type | output | 3 | Queue-side type code |
| issue_lat | output | LAT_W | Hit latency charged |
| done_rd_valid | input | 1 | Read-table completion |
| done_rd_line | input | ADDR_W-LINE_BITS | Line address of read completion |
| done_wr_valid | input | 1 | Write-table completion |
| done_wr_line | input | ADDR_W-LINE_BITS | Line address of write completion |
| done_err | output | 1 | Sticky unmatched-completion flag |
| evt_st_ld | output | EVT_W | Writes rejected by a pending read |
| evt_st_st | output | EVT_W | Writes rejected by a pending write |
| evt_ld_ld | output | EVT_W | Reads rejected by a pending read |
| evt_ld_st | output | EVT_W | Reads rejected by a pending write |

## Verification
The bench probes the line fence after the fencing entry has already left the write table. In that state only the fence can reject a load or store to the line, so a design that tracked locks only through table presence would issue them. It fills the tables to MAX_OUT and then sends a request to a line that is already pending: a design that checked aliasing before capacity would report aliased and bump a counter. A separate case leaves total occupancy under the limit while the read table alone is full, which exposes a design that only compares the grand total. An unmatched completion must raise the error flag and still leave an existing entry visible, so a design that freed the wrong slot would then issue an aliased load.

// File: rtl/mreq_admit_pkg.sv
// Shared kinds, queue types, verdicts and event indices for the admission table.
package mreq_admit_pkg;

    // Primary request kind, kept in the tables.
    typedef enum logic [3:0] {
        K_LOAD  = 4'd0,
        K_FETCH = 4'd1,
        K_STORE = 4'd2,
        K_RMW_RD = 4'd3,
        K_LINK  = 4'd4,
        K_COND  = 4'd5,
        K_LK_RD = 4'd6,
        K_LK_WR = 4'd7,
        K_FLUSH = 4'd8
    } kind_e;

    // Queue-side type sent with an issued request.
    typedef enum logic [2:0] {
        Q_LOAD   = 3'd0,
        Q_FETCH  = 3'd1,
        Q_STORE  = 3'd2,
        Q_ATOMIC = 3'd3,
        Q_FLUSH  = 3'd4
    } qtype_e;

    // Verdict codes.
    typedef enum logic [1:0] {
        S_ISSUED  = 2'd0,
        S_ALIASED = 2'd1,
        S_FULL    = 2'd2
    } status_e;

    localparam int EV_ST_LD = 0;
    localparam int EV_ST_ST = 1;
    localparam int EV_LD_LD = 2;
    localparam int EV_LD_ST = 3;
    localparam int NUM_EV   = 4;

    // Read-class kinds go to the read table, every other kind to the write table.
    function automatic logic is_write_class(kind_e k);
        return !((k == K_LOAD) || (k == K_FETCH));
    endfunction

endpackage

// File: rtl/mreq_classify.sv
// Turns the request flags into a primary kind and a queue-side type.
// Assumes the flags are stable for the cycle; purely combinational.
module mreq_classify
    import mreq_admit_pkg::*;
(
    input  logic   is_llsc,
    input  logic   is_locked,
    input  logic   is_write,
    input  logic   is_flush,
    input  logic   is_fetch,
    input  logic   store_check,
    output kind_e  kind,
    output qtype_e qtype
);

    // Priority decode of the flags.
    always_comb begin
        if (is_llsc) begin
            if (is_write) kind = K_COND;
            else          kind = K_LINK;
            qtype = Q_ATOMIC;
        end else if (is_locked) begin
            if (is_write) kind = K_LK_WR;
            else          kind = K_LK_RD;
            qtype = Q_STORE;
        end else if (is_flush) begin
            kind  = K_FLUSH;
            qtype = Q_FLUSH;
        end else if (is_write) begin
            kind  = K_STORE;
            qtype = Q_STORE;
        end else if (is_fetch) begin
            kind  = K_FETCH;
            qtype = Q_FETCH;
        end else if (store_check) begin
            kind  = K_RMW_RD;
            qtype = Q_STORE;
        end else begin
            kind  = K_LOAD;
            qtype = Q_LOAD;
        end
    end

endmodule

// File: rtl/mreq_line_table.sv
// Small fully associative table of pending line addresses with their kind.
// Assumes the caller never inserts a line that is already held and only
// inserts when has_room is high; a drop that matches nothing changes nothing.
module mreq_line_table
    import mreq_admit_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LAW   = 26
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LAW-1:0]             probe_line,
    output logic                       probe_hit,
    output logic                       has_room,
    output logic [$clog2(DEPTH+1)-1:0] occupancy,
    input  logic                       put_en,
    input  kind_e                      put_kind,
    input  logic                       drop_en,
    input  logic [LAW-1:0]             drop_line,
    output logic                       drop_hit,
    output kind_e                      drop_kind
);

    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DEPTH-1:0] vld;
    logic [LAW-1:0]   line_q [DEPTH];
    kind_e            kind_q [DEPTH];
    logic [DEPTH-1:0] probe_match;
    logic [DEPTH-1:0] drop_match;
    logic [SW-1:0]    slot;

    // Per-entry comparators for the probe and the drop address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign probe_match[i] = vld[i] && (line_q[i] == probe_line);
        assign drop_match[i]  = vld[i] && (line_q[i] == drop_line);
    end

    assign probe_hit = |probe_match;
    assign drop_hit  = |drop_match;
    assign occupancy = CW'($countones(vld));

    // Lowest free entry receives the next insert.
    always_comb begin
        slot     = '0;
        has_room = 1'b0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (!vld[i]) begin
                slot     = SW'(i);
                has_room = 1'b1;
            end
        end
    end

    // Kind of the entry named by the drop address.
    always_comb begin
        drop_kind = K_LOAD;
        for (int i = 0; i < DEPTH; i++) begin
            if (drop_match[i]) drop_kind = kind_q[i];
        end
    end

    // Valid bits: clear the dropped entry, set the inserted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (drop_en && drop_match[i])
                    vld[i] <= 1'b0;
                if (put_en && (slot == SW'(i)))
                    vld[i] <= 1'b1;
            end
        end
    end

    // Entry payload, written on insert only.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (put_en && (slot == SW'(i))) begin
                line_q[i] <= probe_line;
                kind_q[i] <= put_kind;
            end
        end
    end

    AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(probe_match) <= 1); // R3
    AST_PUT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        put_en |-> (has_room && !probe_hit)); // R5

endmodule

// File: rtl/mreq_evt_ctr.sv
// Wrapping event counter, one step per cycle with bump high.
// Assumes the consumer tolerates wrap at 2**W.
module mreq_evt_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] value
);

    // Count the events.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (bump) value <= value + 1'b1;
    end

endmodule

// File: rtl/mreq_admit.sv
// Admission of memory requests into separate read and write line tables.
// Decides issued / aliased / full in one cycle from registered table state,
// forwards accepted requests with queue type and hit latency, frees entries
// on completions and fences a line between a locked read and its locked write.
// Assumes at most one request per cycle; completions use line addresses.
module mreq_admit
    import mreq_admit_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BITS  = 6,
    parameter int TBL_DEPTH  = 8,
    parameter int MAX_OUT    = 10,
    parameter int LAT_W      = 4,
    parameter int ICACHE_LAT = 2,
    parameter int DCACHE_LAT = 3,
    parameter int EVT_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    input  logic                        req_llsc,
    input  logic                        req_locked,
    input  logic                        req_fetch,
    input  logic                        req_flush,
    input  logic                        req_stchk,
    output logic                        rsp_valid,
    output logic [1:0]                  rsp_status,
    output logic                        issue_valid,
    output logic [ADDR_W-1:0]           issue_addr,
    output logic [2:0]                  issue_type,
    output logic [LAT_W-1:0]            issue_lat,
    input  logic                        done_rd_valid,
    input  logic [ADDR_W-LINE_BITS-1:0] done_rd_line,
    input  logic                        done_wr_valid,
    input  logic [ADDR_W-LINE_BITS-1:0] done_wr_line,
    output logic                        done_err,
    output logic [EVT_W-1:0]            evt_st_ld,
    output logic [EVT_W-1:0]            evt_st_st,
    output logic [EVT_W-1:0]            evt_ld_ld,
    output logic [EVT_W-1:0]            evt_ld_st
);

    localparam int LAW = ADDR_W - LINE_BITS;
    localparam int OCW = $clog2(TBL_DEPTH+1);

    kind_e              kind;
    qtype_e             qtype;
    logic [LAW-1:0]     req_line;
    logic               rd_hit, wr_hit, rd_room, wr_room;
    logic [OCW-1:0]     rd_occ, wr_occ;
    logic               rd_drop_hit, wr_drop_hit;
    kind_e              rd_drop_kind, wr_drop_kind;
    int                 total_i;
    logic               over_cap, fenced;
    status_e            verdict;
    logic               put_rd, put_wr;
    logic [NUM_EV-1:0]  ev_hit;
    logic               lock_vld;
    logic [LAW-1:0]     lock_line;
    logic [EVT_W-1:0]   evt_val [NUM_EV];

    assign req_line = req_addr[ADDR_W-1:LINE_BITS];

    mreq_classify u_cls (
        .is_llsc     (req_llsc),
        .is_locked   (req_locked),
        .is_write    (req_write),
        .is_flush    (req_flush),
        .is_fetch    (req_fetch),
        .store_check (req_stchk),
        .kind        (kind),
        .qtype       (qtype)
    );

    mreq_line_table #(.DEPTH(TBL_DEPTH), .LAW(LAW)) u_rd_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_line (req_line),
        .probe_hit  (rd_hit),
        .has_room   (rd_room),
        .occupancy  (rd_occ),
        .put_en     (put_rd),
        .put_kind   (kind),
        .drop_en    (done_rd_valid),
        .drop_line  (done_rd_line),
        .drop_hit   (rd_drop_hit),
        .drop_kind  (rd_drop_kind)
    );

    mreq_line_table #(.DEPTH(TBL_DEPTH), .LAW(LAW)) u_wr_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_line (req_line),
        .probe_hit  (wr_hit),
        .has_room   (wr_room),
        .occupancy  (wr_occ),
        .put_en     (put_wr),
        .put_kind   (kind),
        .drop_en    (done_wr_valid),
        .drop_line  (done_wr_line),
        .drop_hit   (wr_drop_hit),
        .drop_kind  (wr_drop_kind)
    );

    assign total_i  = int'(rd_occ) + int'(wr_occ);
    assign over_cap = (total_i >= MAX_OUT);
    assign fenced   = lock_vld && (lock_line == req_line) && (kind != K_LK_WR);

    // Verdict: capacity, then fence, then cross-table aliasing, then room.
    always_comb begin
        verdict = S_ISSUED;
        ev_hit  = '0;
        put_rd  = 1'b0;
        put_wr  = 1'b0;
        if (req_valid) begin
            if (over_cap) begin
                verdict = S_FULL;
            end else if (fenced) begin
                verdict = S_ALIASED;
            end else if (is_write_class(kind)) begin
                if (rd_hit) begin
                    verdict = S_ALIASED;
                    ev_hit[EV_ST_LD] = 1'b1;
                end else if (wr_hit) begin
                    verdict = S_ALIASED;
                    ev_hit[EV_ST_ST] = 1'b1;
                end else if (!wr_room) begin
                    verdict = S_FULL;
                end else begin
                    put_wr = 1'b1;
                end
            end else begin
                if (wr_hit) begin
                    verdict = S_ALIASED;
                    ev_hit[EV_LD_ST] = 1'b1;
                end else if (rd_hit) begin
                    verdict = S_ALIASED;
                    ev_hit[EV_LD_LD] = 1'b1;
                end else if (!rd_room) begin
                    verdict = S_FULL;
                end else begin
                    put_rd = 1'b1;
                end
            end
        end
    end

    // Register the verdict and the forwarded request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_status  <= 2'd0;
            issue_valid <= 1'b0;
            issue_addr  <= '0;
            issue_type  <= 3'd0;
            issue_lat   <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_status  <= verdict;
            issue_valid <= put_rd | put_wr;
            issue_addr  <= req_addr;
            issue_type  <= qtype;
            issue_lat   <= (qtype == Q_FETCH) ? LAT_W'(ICACHE_LAT) : LAT_W'(DCACHE_LAT);
        end
    end

    // Line fence set by a completed locked read, lifted by its locked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_vld  <= 1'b0;
            lock_line <= '0;
        end else if (done_wr_valid && wr_drop_hit && (wr_drop_kind == K_LK_RD)) begin
            lock_vld  <= 1'b1;
            lock_line <= done_wr_line;
        end else if (done_wr_valid && wr_drop_hit && (wr_drop_kind == K_LK_WR)
                     && (lock_line == done_wr_line)) begin
            lock_vld  <= 1'b0;
        end
    end

    // Sticky flag for completions that match no pending entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_err <= 1'b0;
        else if ((done_rd_valid && !rd_drop_hit) || (done_wr_valid && !wr_drop_hit))
            done_err <= 1'b1;
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_evt
        mreq_evt_ctr #(.W(EVT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .bump  (ev_hit[g]),
            .value (evt_val[g])
        );
    end

    assign evt_st_ld = evt_val[EV_ST_LD];
    assign evt_st_st = evt_val[EV_ST_ST];
    assign evt_ld_ld = evt_val[EV_LD_LD];
    assign evt_ld_st = evt_val[EV_LD_ST];

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        total_i <= MAX_OUT); // R1
    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit && wr_hit)); // R3
    AST_RD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd_valid && rd_drop_hit) |-> (rd_drop_kind == K_LOAD || rd_drop_kind == K_FETCH)); // R2
    AST_FENCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lock_vld && (lock_line == req_line) && (kind != K_LK_WR)) |=> !issue_valid); // R6
    AST_FETCH_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_type == 3'd1) |-> (issue_lat == LAT_W'(ICACHE_LAT))); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |=> done_err); // R9
    AST_ISSUE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (rsp_valid && rsp_status == 2'd0)); // R10

endmodule

// File: tb/mreq_admit_test.sv
`timescale 1ns/1ps
module mreq_admit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0, req_llsc = 1'b0, req_locked = 1'b0;
    logic        req_fetch = 1'b0, req_flush = 1'b0, req_stchk = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic        issue_valid;
    logic [31:0] issue_addr;
    logic [2:0]  issue_type;
    logic [3:0]  issue_lat;
    logic        done_rd_valid = 1'b0, done_wr_valid = 1'b0;
    logic [25:0] done_rd_line = '0, done_wr_line = '0;
    logic        done_err;
    logic [7:0]  evt_st_ld, evt_st_st, evt_ld_ld, evt_ld_st;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mreq_admit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_llsc(req_llsc), .req_locked(req_locked), .req_fetch(req_fetch),
        .req_flush(req_flush), .req_stchk(req_stchk),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .issue_valid(issue_valid), .issue_addr(issue_addr),
        .issue_type(issue_type), .issue_lat(issue_lat),
        .done_rd_valid(done_rd_valid), .done_rd_line(done_rd_line),
        .done_wr_valid(done_wr_valid), .done_wr_line(done_wr_line),
        .done_err(done_err),
        .evt_st_ld(evt_st_ld), .evt_st_st(evt_st_st),
        .evt_ld_ld(evt_ld_ld), .evt_ld_st(evt_ld_st)
    );

    // Flag order {llsc, locked, write, flush, fetch, stchk}
    localparam logic [5:0] F_LD  = 6'b000000;
    localparam logic [5:0] F_IF  = 6'b000010;
    localparam logic [5:0] F_ST  = 6'b001000;
    localparam logic [5:0] F_LL  = 6'b100000;
    localparam logic [5:0] F_SC  = 6'b101000;
    localparam logic [5:0] F_SCK = 6'b000001;
    localparam logic [5:0] F_FL  = 6'b000100;
    localparam logic [5:0] F_LKR = 6'b010000;
    localparam logic [5:0] F_LKW = 6'b011000;

    // {flags, addr, status, type, lat}
    localparam int NV = 13;
    localparam logic [46:0] VEC [NV] = '{
        {F_LD,  32'h0000_1000, 2'd0, 3'd0, 4'd3},
        {F_IF,  32'h0000_2004, 2'd0, 3'd1, 4'd2},
        {F_LD,  32'h0000_1020, 2'd1, 3'd0, 4'd0},
        {F_ST,  32'h0000_1008, 2'd1, 3'd0, 4'd0},
        {F_ST,  32'h0000_3000, 2'd0, 3'd2, 4'd3},
        {F_ST,  32'h0000_3010, 2'd1, 3'd0, 4'd0},
        {F_LD,  32'h0000_3030, 2'd1, 3'd0, 4'd0},
        {F_LL,  32'h0000_4000, 2'd0, 3'd3, 4'd3},
        {F_SC,  32'h0000_5000, 2'd0, 3'd3, 4'd3},
        {F_SCK, 32'h0000_6000, 2'd0, 3'd2, 4'd3},
        {F_FL,  32'h0000_7000, 2'd0, 3'd4, 4'd3},
        {F_LKR, 32'h0000_8000, 2'd0, 3'd2, 4'd3},
        {F_IF,  32'h0000_5010, 2'd1, 3'd0, 4'd0}
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Drive one request for one cycle; outputs are sampled on return.
    task automatic send(input logic [5:0] f, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        {req_llsc, req_locked, req_write, req_flush, req_fetch, req_stchk} = f;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string rq, input logic [1:0] st,
                              input logic [2:0] ty, input logic [3:0] lat);
        chk(rq, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rq, "rsp_status", 32'(rsp_status), 32'(st));
        chk(rq, "issue_valid", 32'(issue_valid), 32'(st == 2'd0));
        if (st == 2'd0) begin
            chk(rq, "issue_type", 32'(issue_type), 32'(ty));
            chk(rq, "issue_lat", 32'(issue_lat), 32'(lat));
            chk(rq, "issue_addr", issue_addr, req_addr);
        end
    endtask

    task automatic done_wr(input logic [31:0] a);
        @(negedge clk);
        done_wr_valid = 1'b1; done_wr_line = a[31:6];
        @(negedge clk);
        done_wr_valid = 1'b0;
    endtask

    task automatic done_rd(input logic [31:0] a);
        @(negedge clk);
        done_rd_valid = 1'b1; done_rd_line = a[31:6];
        @(negedge clk);
        done_rd_valid = 1'b0;
    endtask

    task automatic chk_evt(input string rq, input int sl, input int ss,
                           input int ll, input int ls);
        chk(rq, "evt_st_ld", 32'(evt_st_ld), 32'(sl));
        chk(rq, "evt_st_st", 32'(evt_st_st), 32'(ss));
        chk(rq, "evt_ld_ld", 32'(evt_ld_ld), 32'(ll));
        chk(rq, "evt_ld_st", 32'(evt_ld_st), 32'(ls));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10", "issue_valid", 32'(issue_valid), 32'd0);
        chk("R9", "done_err", 32'(done_err), 32'd0);
        chk_evt("R10", 0, 0, 0, 0);

        // Vector walk: classification R2, R7, R8, aliasing R3, R4
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][46:41], VEC[i][40:9]);
            expect_rsp($sformatf("R2/R3/R4/R7/R8 vec%0d", i),
                       VEC[i][8:7], VEC[i][6:4], VEC[i][3:0]);
        end
        @(negedge clk);
        chk("R10", "rsp_valid idle", 32'(rsp_valid), 32'd0);
        chk_evt("R3/R4 counters", 1, 1, 1, 2);

        // R6 fence: locked read done, entry freed but line still fenced
        done_wr(32'h8000);
        send(F_LD, 32'h8010);
        expect_rsp("R6 load fenced", 2'd1, 3'd0, 4'd0);
        send(F_ST, 32'h8000);
        expect_rsp("R6 store fenced", 2'd1, 3'd0, 4'd0);
        chk_evt("R6 no count", 1, 1, 1, 2);
        send(F_LKW, 32'h8000);
        expect_rsp("R6 locked write passes", 2'd0, 3'd2, 4'd3);
        done_wr(32'h8000);
        send(F_LD, 32'h8000);
        expect_rsp("R6 fence lifted", 2'd0, 3'd0, 4'd3);
        chk("R9", "done_err after good completions", 32'(done_err), 32'd0);

        // R1 total capacity: now 8 pending, fill to 10
        send(F_LD, 32'h9000);
        expect_rsp("R1 fill", 2'd0, 3'd0, 4'd3);
        send(F_LD, 32'hA000);
        expect_rsp("R1 fill", 2'd0, 3'd0, 4'd3);
        send(F_ST, 32'hB000);
        expect_rsp("R1 full", 2'd2, 3'd0, 4'd0);
        send(F_LD, 32'h1000);
        expect_rsp("R1 full beats alias", 2'd2, 3'd0, 4'd0);
        chk_evt("R1 no count", 1, 1, 1, 2);

        // R5 read table full while total below limit; R9 frees
        done_wr(32'h3000);
        done_wr(32'h4000);
        done_wr(32'h5000);
        done_wr(32'h6000);
        send(F_LD, 32'hC000);
        expect_rsp("R5 fill", 2'd0, 3'd0, 4'd3);
        send(F_LD, 32'hD000);
        expect_rsp("R5 fill", 2'd0, 3'd0, 4'd3);
        send(F_LD, 32'hE000);
        expect_rsp("R5 fill", 2'd0, 3'd0, 4'd3);
        send(F_LD, 32'hF000);
        expect_rsp("R5 table full", 2'd2, 3'd0, 4'd0);

        // R9 unmatched completion
        chk("R9", "done_err before", 32'(done_err), 32'd0);
        done_rd(32'h3F000);
        chk("R9", "done_err set", 32'(done_err), 32'd1);
        send(F_LD, 32'h1000);
        expect_rsp("R9 tables unchanged", 2'd1, 3'd0, 4'd0);
        chk_evt("R4 ld_ld", 1, 1, 2, 2);
        send(F_ST, 32'h3000);
        expect_rsp("R9 freed line reusable", 2'd0, 3'd2, 4'd3);
        chk("R9", "done_err sticky", 32'(done_err), 32'd1);

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "issue_valid after reset", 32'(issue_valid), 32'd0);
        chk("R10", "done_err after reset", 32'(done_err), 32'd0);
        chk_evt("R10 after reset", 0, 0, 0, 0);
        send(F_LD, 32'h1000);
        expect_rsp("R10 tables emptied", 2'd0, 3'd0, 4'd3);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule